// File: doc/BRIEF.md
# Configurable Binary Correlation Array

This block slides a stream of input samples past a stored one-bit reference pattern. It produces, every clock, a count of how many tap positions agree with that pattern. The tap array is 256 one-bit positions, built as eight stages of 32 taps. The stages are regrouped by a width selector. With one-bit samples all eight stages form one 256-tap line. Wider samples are split into bit planes. Each plane runs through its own chain of stages, so 2, 4 or 8-bit samples give planes of 128, 64 or 32 taps, and each plane gets its own match count.

A split selector cuts the array into two independent correlators of four stages each. They are fed from the low and high halves of the sample bus. A per-tap mask removes chosen positions from the count.

The reference and the mask each have a background copy that loads serially, one bit per clock. A one-cycle transfer strobe moves both background copies into the active copies on the same edge. A new pattern can therefore be prepared while the current one keeps scoring. The oldest tap of every stage and the outgoing bit of each background register are driven out, so that arrays can be chained.

Top module: `corr_array`

## Requirements
- R1: While `rst_n` is low, all taps, both background registers and both active registers are cleared, and `score`, `tap_out`, `ref_chain` and `msk_chain` read zero.
- R2: `wsel` selects the sample width: 0 gives 1 bit, 1 gives 2 bits, 2 gives 4 bits and 3 gives 8 bits. With `split` low, sample bit j feeds plane j, which spans stages j·L to j·L+L−1 where L = 8/width. Each plane therefore has 256/width taps.
- R3: Within a stage, tap 0 takes the new bit and tap 31 is the oldest. Tap 31 of a stage feeds tap 0 of the next stage in the same plane. Global tap index k = 32·stage + tap lines up with bit k of the reference and of the mask.
- R4: A tap matches when its data bit equals its active reference bit and its active mask bit is 0. Field `score[9j+8:9j]` is the match count over the stages of plane j. It is registered, so it reflects the tap state before the clock edge that loads it.
- R5: A score field whose plane has no stage in the current mode reads zero.
- R6: With `split` high, stages 0–3 form one correlator fed from `din[3:0]` and stages 4–7 form another fed from `din[7:4]`. Width 1, 2 or 4 gives planes of 128, 64 or 32 taps per half. `wsel`=3 acts as 4 bits.
- R7: When `ref_shift` or `msk_shift` is high, the background register shifts its input bit into index 0 and moves every bit one index up. A background register that is only shifted never changes the score.
- R8: When `xfer` is high at a clock edge, the active reference and the active mask both take the background values held before that edge, including when a shift happens in the same cycle. Without `xfer` the active copies hold.
- R9: With every active mask bit set, all score fields are zero. No score field sum ever exceeds the number of unmasked taps.
- R10: `tap_out[s]` is the oldest tap of stage s. `ref_chain` and `msk_chain` are bit 255 of the background reference and mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Sample bus, one bit per plane |
| wsel | input | 2 | Sample width code |
| split | input | 1 | Two independent correlators when high |
| ref_bit | input | 1 | Serial bit for the background reference |
| ref_shift | input | 1 | Shift enable for the background reference |
| msk_bit | input | 1 | Serial bit for the background mask |
| msk_shift | input | 1 | Shift enable for the background mask |
| xfer | input | 1 | Copy background reference and mask into the active copies |
| score | output | 72 | Eight 9-bit per-plane match counts |
| tap_out | output | 8 | Oldest tap of each stage |
| ref_chain | output | 1 | Outgoing bit of the background reference |
| msk_chain | output | 1 | Outgoing bit of the background mask |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- tap shifting and entry;
- serial entry into the background registers;
- holding of the active copies without a transfer, and their exact copy on a transfer;
- the bound of the summed score by the unmasked tap count.

The remaining behaviour needs whole scenarios, driven against a bench model that keeps its own tap image:
- the routing of sample bits into planes for each width, with and without split;
- per-plane counts under random masks;
- zero reads on unused planes;
- the transfer landing on a shifting cycle.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // log2 of the effective sample width, clamped to the group size
  function automatic int eff_wlog(input logic [1:0] wsel, input logic split,
                                  input int stg_log);
    int glog;
    glog = stg_log - (split ? 1 : 0);
    return (int'(wsel) > glog) ? glog : int'(wsel);
  endfunction

  // sample bus bit that owns stage s
  function automatic int src_plane(input int s, input logic [1:0] wsel,
                                   input logic split, input int stg_log);
    int glog, llog, h, ls;
    glog = stg_log - (split ? 1 : 0);
    llog = glog - eff_wlog(wsel, split, stg_log);
    h    = s >> glog;
    ls   = s - (h << glog);
    return (h << glog) + (ls >> llog);
  endfunction

  // stage s is the first stage of its plane
  function automatic logic is_head(input int s, input logic [1:0] wsel,
                                   input logic split, input int stg_log);
    int glog, llog, ls;
    glog = stg_log - (split ? 1 : 0);
    llog = glog - eff_wlog(wsel, split, stg_log);
    ls   = s - ((s >> glog) << glog);
    return (ls & ((1 << llog) - 1)) == 0;
  endfunction

endpackage

// File: rtl/corr_stage.sv
module corr_stage #(
  parameter int TAPS = 32,
  parameter int CW   = $clog2(TAPS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sin,
  input  logic [TAPS-1:0] ref_act,
  input  logic [TAPS-1:0] msk_act,
  output logic            sout,
  output logic [CW-1:0]   cnt
);
  logic [TAPS-1:0] taps;
  logic [TAPS-1:0] hit;
  logic            armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps  <= '0;
      armed <= 1'b0;
    end else begin
      taps  <= {taps[TAPS-2:0], sin};
      armed <= 1'b1;
    end
  end

  assign sout = taps[TAPS-1];
  assign hit  = ~(taps ^ ref_act) & ~msk_act;

  always_comb begin
    cnt = '0;
    for (int t = 0; t < TAPS; t++) cnt = cnt + CW'(hit[t]);
  end

  AST_TAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> taps[0] == $past(sin)); // R3
  AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> taps[TAPS-1:1] == $past(taps[TAPS-2:0])); // R3

endmodule

// File: rtl/corr_pattern_buf.sv
module corr_pattern_buf #(
  parameter int N = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         shift,
  input  logic         xfer,
  output logic         chain,
  output logic [N-1:0] active
);
  logic [N-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (shift) shadow <= {shadow[N-2:0], bit_in};
      if (xfer)  active <= shadow;
    end
  end

  assign chain = shadow[N-1];

  AST_SHADOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> shadow[0] == $past(bit_in)); // R7
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(active)); // R8
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> active == $past(shadow)); // R8

endmodule

// File: rtl/corr_plane_sum.sv
module corr_plane_sum #(
  parameter int STAGES  = 8,
  parameter int CW      = 6,
  parameter int SCW     = 9,
  parameter int STG_LOG = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STAGES*CW-1:0]  stage_cnt,
  input  logic [1:0]            wsel,
  input  logic                  split,
  output logic [STAGES*SCW-1:0] score
);
  logic [SCW-1:0] acc [STAGES];

  always_comb begin
    for (int j = 0; j < STAGES; j++) begin
      acc[j] = '0;
      for (int s = 0; s < STAGES; s++)
        if (corr_pkg::src_plane(s, wsel, split, STG_LOG) == j)
          acc[j] = acc[j] + SCW'(stage_cnt[s*CW +: CW]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) score <= '0;
    else
      for (int j = 0; j < STAGES; j++) score[j*SCW +: SCW] <= acc[j];
  end

endmodule

// File: rtl/corr_array.sv
module corr_array #(
  parameter int STAGES = 8,
  parameter int TAPS   = 32,
  localparam int NTAP    = STAGES * TAPS,
  localparam int STG_LOG = $clog2(STAGES),
  localparam int CW      = $clog2(TAPS + 1),
  localparam int SCW     = $clog2(NTAP + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STAGES-1:0]     din,
  input  logic [1:0]            wsel,
  input  logic                  split,
  input  logic                  ref_bit,
  input  logic                  ref_shift,
  input  logic                  msk_bit,
  input  logic                  msk_shift,
  input  logic                  xfer,
  output logic [STAGES*SCW-1:0] score,
  output logic [STAGES-1:0]     tap_out,
  output logic                  ref_chain,
  output logic                  msk_chain
);
  logic [NTAP-1:0]      ref_act;
  logic [NTAP-1:0]      msk_act;
  logic [STAGES-1:0]    stg_out;
  logic [STAGES*CW-1:0] stg_cnt;

  corr_pattern_buf #(.N(NTAP)) u_ref (
    .clk(clk), .rst_n(rst_n), .bit_in(ref_bit), .shift(ref_shift),
    .xfer(xfer), .chain(ref_chain), .active(ref_act));

  corr_pattern_buf #(.N(NTAP)) u_msk (
    .clk(clk), .rst_n(rst_n), .bit_in(msk_bit), .shift(msk_shift),
    .xfer(xfer), .chain(msk_chain), .active(msk_act));

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic               sin;
    logic [STG_LOG-1:0] pick;
    assign pick = STG_LOG'(corr_pkg::src_plane(s, wsel, split, STG_LOG));
    if (s == 0) begin : g_first
      assign sin = din[pick];
    end else begin : g_rest
      assign sin = corr_pkg::is_head(s, wsel, split, STG_LOG) ? din[pick]
                                                              : stg_out[s-1];
    end
    corr_stage #(.TAPS(TAPS), .CW(CW)) u_stage (
      .clk(clk), .rst_n(rst_n), .sin(sin),
      .ref_act(ref_act[s*TAPS +: TAPS]), .msk_act(msk_act[s*TAPS +: TAPS]),
      .sout(stg_out[s]), .cnt(stg_cnt[s*CW +: CW]));
  end

  assign tap_out = stg_out;

  corr_plane_sum #(.STAGES(STAGES), .CW(CW), .SCW(SCW), .STG_LOG(STG_LOG)) u_sum (
    .clk(clk), .rst_n(rst_n), .stage_cnt(stg_cnt), .wsel(wsel),
    .split(split), .score(score));

  int score_total;
  always_comb begin
    score_total = 0;
    for (int j = 0; j < STAGES; j++) score_total = score_total + int'(score[j*SCW +: SCW]);
  end

  AST_MASK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    score_total <= NTAP - $countones($past(msk_act))); // R9

endmodule

// File: tb/corr_array_test.sv
module corr_array_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  din;
  logic [1:0]  wsel;
  logic        split, ref_bit, ref_shift, msk_bit, msk_shift, xfer;
  logic [71:0] score;
  logic [7:0]  tap_out;
  logic        ref_chain, msk_chain;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NT-1:0] m_dat, m_ref, m_msk, m_rsh, m_msh;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_array uut (
    .clk(clk), .rst_n(rst_n), .din(din), .wsel(wsel), .split(split),
    .ref_bit(ref_bit), .ref_shift(ref_shift), .msk_bit(msk_bit),
    .msk_shift(msk_shift), .xfer(xfer), .score(score), .tap_out(tap_out),
    .ref_chain(ref_chain), .msk_chain(msk_chain));

  function automatic int bwidth(input int ws, input bit sp);
    int w;
    w = 1 << ws;
    if (sp && w > 4) w = 4;
    return w;
  endfunction

  function automatic int bsrc(input int s, input int ws, input bit sp);
    int w;
    w = bwidth(ws, sp);
    if (sp) return (s / 4) * 4 + (s % 4) / (4 / w);
    return s / (8 / w);
  endfunction

  function automatic bit bhead(input int s, input int ws, input bit sp);
    int per;
    per = (sp ? 4 : 8) / bwidth(ws, sp);
    return (s % per) == 0;
  endfunction

  function automatic bit plane_used(input int j, input int ws, input bit sp);
    for (int s = 0; s < 8; s++) if (bsrc(s, ws, sp) == j) return 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    int ex [8];
    logic [NT-1:0] nd;
    int k;
    for (int j = 0; j < 8; j++) ex[j] = 0;
    for (int i = 0; i < NT; i++)
      if (m_dat[i] == m_ref[i] && !m_msk[i]) ex[bsrc(i / 32, wsel, split)]++;
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 32; t++) begin
        k = s * 32 + t;
        if (t == 0 && (s == 0 || bhead(s, wsel, split)))
          nd[k] = din[bsrc(s, wsel, split)];
        else
          nd[k] = m_dat[k-1];
      end
    if (xfer) begin
      m_ref = m_rsh;
      m_msk = m_msh;
    end
    if (ref_shift) m_rsh = {m_rsh[NT-2:0], ref_bit};
    if (msk_shift) m_msh = {m_msh[NT-2:0], msk_bit};
    m_dat = nd;
    @(posedge clk);
    @(negedge clk);
    for (int j = 0; j < 8; j++)
      chk(int'(score[j*9 +: 9]) == ex[j], plane_used(j, wsel, split) ? tag : "R5",
          $sformatf("score plane %0d", j), int'(score[j*9 +: 9]), ex[j]);
    for (int s = 0; s < 8; s++)
      chk(tap_out[s] == m_dat[s*32+31], "R10", $sformatf("tap_out[%0d]", s),
          int'(tap_out[s]), int'(m_dat[s*32+31]));
    chk(ref_chain == m_rsh[NT-1], "R10", "ref_chain", int'(ref_chain), int'(m_rsh[NT-1]));
    chk(msk_chain == m_msh[NT-1], "R10", "msk_chain", int'(msk_chain), int'(m_msh[NT-1]));
  endtask

  task automatic load(input logic [NT-1:0] p, input logic [NT-1:0] m,
                      input string tag, input bit xfer_last);
    for (int i = NT - 1; i >= 0; i--) begin
      ref_bit = p[i]; msk_bit = m[i];
      ref_shift = 1'b1; msk_shift = 1'b1;
      xfer = xfer_last && (i == 0);
      din = 8'($urandom);
      tick(tag);
    end
    ref_shift = 1'b0; msk_shift = 1'b0; xfer = 1'b0;
  endtask

  function automatic logic [NT-1:0] rnd_bits(input int one_in);
    logic [NT-1:0] v;
    for (int i = 0; i < NT; i++) v[i] = (($urandom % one_in) == 0);
    return v;
  endfunction

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      din = 8'($urandom);
      tick(tag);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; din = '1; wsel = 2'd0; split = 1'b0;
    ref_bit = 1'b1; ref_shift = 1'b1; msk_bit = 1'b1; msk_shift = 1'b1; xfer = 1'b1;
    m_dat = '0; m_ref = '0; m_msk = '0; m_rsh = '0; m_msh = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: everything cleared while reset is held
    chk(score == '0, "R1", "score in reset", int'(score[8:0]), 0);
    chk(tap_out == '0, "R1", "tap_out in reset", int'(tap_out), 0);
    chk(ref_chain == 1'b0 && msk_chain == 1'b0, "R1", "chains in reset",
        int'({ref_chain, msk_chain}), 0);
    ref_shift = 1'b0; msk_shift = 1'b0; xfer = 1'b0; din = '0;
    rst_n = 1'b1;
    // R4: all-zero taps, reference and mask give a full 256 count
    tick("R4");
    chk(score[8:0] == 9'd256, "R4", "full match after reset", int'(score[8:0]), 256);
    run(40, "R3");

    // R7: background load does not disturb scoring; R8: transfer
    load(rnd_bits(2), '0, "R7", 1'b0);
    xfer = 1'b1; din = 8'($urandom); tick("R8"); xfer = 1'b0;
    run(300, "R4");

    // R2: each width without split, random masks
    for (int ws = 0; ws < 4; ws++) begin
      wsel = 2'(ws); split = 1'b0;
      load(rnd_bits(2), rnd_bits(4), "R7", 1'b0);
      xfer = 1'b1; tick("R8"); xfer = 1'b0;
      run(300, "R2");
    end

    // R6: split mode at each width code, including the clamped code 3
    for (int ws = 0; ws < 4; ws++) begin
      wsel = 2'(ws); split = 1'b1;
      load(rnd_bits(2), rnd_bits(5), "R7", 1'b0);
      xfer = 1'b1; tick("R8"); xfer = 1'b0;
      run(200, "R6");
    end

    // R8: transfer on the same cycle as the last shift takes the pre-shift copy
    wsel = 2'd1; split = 1'b0;
    load(rnd_bits(2), rnd_bits(3), "R8", 1'b1);
    run(50, "R8");

    // R9: full mask zeroes every field
    load(rnd_bits(2), '1, "R7", 1'b0);
    xfer = 1'b1; tick("R8"); xfer = 1'b0;
    run(60, "R9");
    chk(score == '0, "R9", "all masked score", int'(score[8:0]), 0);

    // R3: data equal to reference on one plane gives full length
    wsel = 2'd0; split = 1'b0;
    load('0, '0, "R7", 1'b0);
    xfer = 1'b1; tick("R8"); xfer = 1'b0;
    din = '0;
    for (int i = 0; i < NT; i++) tick("R3");
    chk(score[8:0] == 9'd256, "R3", "aligned zero stream", int'(score[8:0]), 256);

    done = 1;
    summary();
  end

endmodule